// File: doc/BRIEF.md
# Memory Bus Write and Read Cycle Capture

This block sits behind the pins of a byte-wide asynchronous memory port and turns its control strobes into clean, single-cycle events in the system clock domain. The three active-low strobes (chip select, output enable, write enable) are brought in through multi-flop synchronizers. The address and data buses pass through a register pipeline of equal depth, so every bus sample lines up with the strobe sample taken in the same clock. A command controller downstream sees one write event per bus write cycle and one read event per bus read cycle, each with its captured address and, for writes, the captured byte.

A write cycle is the interval during which chip select and write enable are both low while output enable is high. The address is taken from the sample in which that interval begins, whichever strobe falls last. The data byte is taken from the last sample inside the interval, and the write event follows when either strobe rises first. Read cycles (select and output enable low, write enable high) normally report their address at the start of the cycle. While the controller tracks a software protection sequence, it raises a mode input, and reads then report the address held at the end of the cycle, when output enable or select rises first. The block also drives the enable for the data output buffers.

Top module: `bus_cycle_capture`

## Requirements
- R1: While chip select is high in the synchronized samples, no write event and no read event is issued, whatever the other strobes do.
- R2: `dq_oe` is 1 exactly when the synchronized chip select and output enable are both low; it follows a pin change after two rising clock edges.
- R3: A write event carries the address sampled in the first clock where chip select and write enable are both low, even if the address bus changes later in the cycle.
- R4: A write event carries the data byte sampled in the last clock where chip select and write enable are both low. It is issued on the third rising edge after the pins first show either strobe high again.
- R5: A write interval during which output enable is low in any sample produces no write event.
- R6: With `prot_track` = 0, a read cycle issues one read event at its start, carrying the address sampled in the first clock of the read.
- R7: With `prot_track` = 1, a read cycle issues one read event when output enable or chip select rises first, carrying the address sampled in the last clock of the read.
- R8: Each write event and each read event is a pulse exactly one clock wide, one per bus cycle.
- R9: A read event and a write event never share a clock. When a read would start in the same clock that a write ends, the write event is issued first and the read event follows in the next clock with its own address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Asynchronous chip select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| we_n | input | 1 | Asynchronous write enable, active low |
| bus_addr | input | 19 | Address bus from the pins |
| bus_data | input | 8 | Data bus from the pins (write direction) |
| prot_track | input | 1 | 1 while a protection read sequence is tracked; change only while chip select is high |
| dq_oe | output | 1 | Enable for the data output buffers |
| write_evt | output | 1 | One-clock pulse per accepted write cycle |
| wr_addr | output | 19 | Address of the write event |
| wr_data | output | 8 | Data byte of the write event |
| read_evt | output | 1 | One-clock pulse per read cycle |
| rd_addr | output | 19 | Address of the read event |

## Verification
The only two events that can collide are the end of a write and the start of a read. This happens when write enable rises and output enable falls in the same sample while chip select stays low. The bench provokes this case by moving both strobes on one clock edge, with a different address on the bus at that moment. It then checks that the write event comes first with the older address and byte, that the read event follows exactly one clock later with the newer address, and that no clock ever carries both pulses.

// File: rtl/bcc_pkg.sv
// Package: shared types for the memory bus cycle capture block.
// Assumes: strobes are active low and sampled together.
package bcc_pkg;

    // One synchronized sample of the three bus strobes.
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } bus_ctl_t;

    localparam int CTL_W = $bits(bus_ctl_t);

endpackage

// File: rtl/bcc_pipe.sv
// Module: bcc_pipe
// A chain of STAGES registers. It serves as a synchronizer for the
// asynchronous strobes and as the matching delay line for the address and
// data buses, so that all samples of one clock stay aligned.
// Assumes: STAGES >= 1; reset is synchronous and active low.
module bcc_pipe #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Take the raw input into the first register.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // Shift the previous stage forward by one clock.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= RST_VAL;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/bcc_cycle_core.sv
// Module: bcc_cycle_core
// Decodes bus cycles from aligned strobe, address and data samples.
// It compares each sample with the one before it to find where a write
// interval or a read interval starts and ends, latches address and data at
// those points, and issues one-clock events. A read that collides with the
// end of a write is held back by one clock.
// Assumes: inputs are already synchronous and aligned; prot_track changes
// only while chip select is high.
module bcc_cycle_core
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ctl_t          ctl_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic              prot_track,
    output logic              dq_oe,
    output logic              write_evt,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              read_evt,
    output logic [ADDR_W-1:0] rd_addr
);

    bus_ctl_t          ctl_p;
    logic [ADDR_W-1:0] addr_p;
    logic [DATA_W-1:0] data_p;
    logic [ADDR_W-1:0] wa_hold;
    logic              armed;
    logic              pend;
    logic [ADDR_W-1:0] pend_addr;

    logic wsel, wsel_p, rsel, rsel_p;
    logic w_start, w_end, r_start, r_end;
    logic wr_fire, rd_req;
    logic [ADDR_W-1:0] rd_req_addr;

    // Interval decode on the current and the previous sample.
    assign wsel    = !ctl_s.ce_n && !ctl_s.we_n;
    assign wsel_p  = !ctl_p.ce_n && !ctl_p.we_n;
    assign rsel    = !ctl_s.ce_n && !ctl_s.oe_n && ctl_s.we_n;
    assign rsel_p  = !ctl_p.ce_n && !ctl_p.oe_n && ctl_p.we_n;
    assign w_start = wsel && !wsel_p;
    assign w_end   = !wsel && wsel_p;
    assign r_start = rsel && !rsel_p;
    assign r_end   = !rsel && rsel_p;
    assign wr_fire = w_end && armed;

    // Output buffers drive only when selected and output enable is low.
    assign dq_oe = !ctl_s.ce_n && !ctl_s.oe_n;

    // Choose which read edge reports, and which address it carries.
    always_comb begin
        if (prot_track) begin
            rd_req      = r_end;
            rd_req_addr = addr_p;
        end else begin
            rd_req      = r_start;
            rd_req_addr = addr_s;
        end
    end

    // Keep the previous sample for edge detection and end-of-interval data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_p  <= '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};
            addr_p <= '0;
            data_p <= '0;
        end else begin
            ctl_p  <= ctl_s;
            addr_p <= addr_s;
            data_p <= data_s;
        end
    end

    // Track whether the current write interval is still valid (OE high throughout).
    always_ff @(posedge clk) begin
        if (!rst_n)                   armed <= 1'b0;
        else if (w_start)             armed <= ctl_s.oe_n;
        else if (wsel && !ctl_s.oe_n) armed <= 1'b0;
        else if (w_end)               armed <= 1'b0;
    end

    // Latch the write address where the later strobe falls.
    always_ff @(posedge clk) begin
        if (!rst_n)       wa_hold <= '0;
        else if (w_start) wa_hold <= addr_s;
    end

    // Issue the write event with the last data inside the interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_evt <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            write_evt <= wr_fire;
            if (wr_fire) begin
                wr_addr <= wa_hold;
                wr_data <= data_p;
            end
        end
    end

    // Hold back a read that collides with a write event by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_addr <= '0;
        end else begin
            pend <= wr_fire && rd_req;
            if (wr_fire && rd_req) pend_addr <= rd_req_addr;
        end
    end

    // Issue the read event, a held-back read first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            read_evt <= 1'b0;
            rd_addr  <= '0;
        end else begin
            read_evt <= pend || (rd_req && !wr_fire);
            if (pend)                   rd_addr <= pend_addr;
            else if (rd_req && !wr_fire) rd_addr <= rd_req_addr;
        end
    end

    // R9: the two event kinds never share a clock.
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(write_evt && read_evt));

    // R8: a write event lasts exactly one clock.
    a_r8_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        write_evt |=> !write_evt);

    // R1: two deselected samples in a row give no event in the next clock.
    a_r1_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_s.ce_n && ctl_p.ce_n) |=> !(write_evt || read_evt));

    // R5: a write event needs output enable high in the last selected sample.
    a_r5_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        write_evt |-> $past(ctl_p.oe_n));

endmodule

// File: rtl/bus_cycle_capture.sv
// Module: bus_cycle_capture (top)
// Front end for an asynchronous byte-wide memory port. It synchronizes the
// strobes, delays the buses by the same depth and hands the aligned samples
// to the cycle decoder.
// Assumes: the buses are stable around strobe edges for at least one clock;
// prot_track changes only while ce_n is high.
module bus_cycle_capture
    import bcc_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              prot_track,
    output logic              dq_oe,
    output logic              write_evt,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              read_evt,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam int BUS_W = ADDR_W + DATA_W;

    bus_ctl_t          ctl_raw, ctl_s;
    logic [BUS_W-1:0]  bus_s;

    assign ctl_raw = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n};

    bcc_pipe #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_s)
    );

    bcc_pipe #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_addr, bus_data}),
        .q     (bus_s)
    );

    bcc_cycle_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_s      (ctl_s),
        .addr_s     (bus_s[BUS_W-1:DATA_W]),
        .data_s     (bus_s[DATA_W-1:0]),
        .prot_track (prot_track),
        .dq_oe      (dq_oe),
        .write_evt  (write_evt),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .read_evt   (read_evt),
        .rd_addr    (rd_addr)
    );

endmodule

// File: tb/sim_bus_cycle_capture.sv
// Directed bench for bus_cycle_capture. Inputs change on falling clock
// edges; a monitor on falling edges records every event pulse.
module sim_bus_cycle_capture;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [18:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        prot_track = 1'b0;
    logic        dq_oe, write_evt, read_evt;
    logic [18:0] wr_addr, rd_addr;
    logic [7:0]  wr_data;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    int wr_cnt = 0, rd_cnt = 0, both_cnt = 0;
    int wr_cyc = 0, rd_cyc = 0;
    logic [18:0] last_wa = '0, last_ra = '0;
    logic [7:0]  last_wd = '0;

    bus_cycle_capture u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .bus_addr(bus_addr), .bus_data(bus_data), .prot_track(prot_track),
        .dq_oe(dq_oe), .write_evt(write_evt), .wr_addr(wr_addr),
        .wr_data(wr_data), .read_evt(read_evt), .rd_addr(rd_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Record event pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (write_evt) begin
                wr_cnt++; last_wa = wr_addr; last_wd = wr_data; wr_cyc = cyc;
            end
            if (read_evt) begin
                rd_cnt++; last_ra = rd_addr; rd_cyc = cyc;
            end
            if (write_evt && read_evt) both_cnt++;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        step(1);
        chk(dq_oe == 1'b0, "R2 reset", int'(dq_oe), 0);
        chk(write_evt == 1'b0, "R8 reset", int'(write_evt), 0);
        chk(read_evt == 1'b0, "R8 reset", int'(read_evt), 0);
    endtask

    // R3/R4: write with address moving after start and data moving inside.
    task automatic t_write_basic();
        int w0, t_end;
        w0 = wr_cnt;
        step(1);
        bus_addr = 19'h1_2345; bus_data = 8'h11; ce_n = 1'b0; we_n = 1'b0;
        step(1); bus_addr = 19'h7_0F0F;
        step(1); bus_data = 8'hA5;
        step(2);
        we_n = 1'b1; bus_data = 8'h00; t_end = cyc;
        step(5); ce_n = 1'b1; step(4);
        chk(wr_cnt == w0 + 1, "R8 one write", wr_cnt - w0, 1);
        chk(last_wa == 19'h1_2345, "R3 write addr", int'(last_wa), 'h12345);
        chk(last_wd == 8'hA5, "R4 write data", int'(last_wd), 'hA5);
        chk(wr_cyc - t_end == 3, "R4 latency", wr_cyc - t_end, 3);
    endtask

    // R3: write enable falls first, chip select falls later and rises first.
    task automatic t_write_ce_late();
        int w0;
        w0 = wr_cnt;
        step(1);
        bus_addr = 19'h0_0001; we_n = 1'b0; step(3);
        bus_addr = 19'h5_5555; bus_data = 8'h3C; ce_n = 1'b0;
        step(1); bus_addr = 19'h0_0002;
        step(3); ce_n = 1'b1; bus_data = 8'hFF;
        step(2); we_n = 1'b1; step(5);
        chk(wr_cnt == w0 + 1, "R8 one write ce", wr_cnt - w0, 1);
        chk(last_wa == 19'h5_5555, "R3 later fall addr", int'(last_wa), 'h55555);
        chk(last_wd == 8'h3C, "R4 earlier rise data", int'(last_wd), 'h3C);
    endtask

    // R5: output enable low during a write suppresses it.
    task automatic t_inhibit();
        int w0;
        w0 = wr_cnt;
        step(1);
        oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; bus_addr = 19'h111; step(4);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1; step(5);
        chk(wr_cnt == w0, "R5 oe low whole write", wr_cnt - w0, 0);
        ce_n = 1'b0; we_n = 1'b0; step(3);
        oe_n = 1'b0; step(1); oe_n = 1'b1; step(3);
        we_n = 1'b1; step(1); ce_n = 1'b1; step(5);
        chk(wr_cnt == w0, "R5 oe pulse mid write", wr_cnt - w0, 0);
    endtask

    // R1/R2: deselected activity is ignored and keeps buffers off.
    task automatic t_deselect();
        int w0, r0;
        w0 = wr_cnt; r0 = rd_cnt;
        step(1);
        we_n = 1'b0; step(3); we_n = 1'b1; step(2);
        oe_n = 1'b0; step(2);
        chk(dq_oe == 1'b0, "R2 deselected hi-z", int'(dq_oe), 0);
        oe_n = 1'b1; step(5);
        chk(wr_cnt == w0, "R1 no write deselected", wr_cnt - w0, 0);
        chk(rd_cnt == r0, "R1 no read deselected", rd_cnt - r0, 0);
    endtask

    // R2/R6: normal read reports at start, buffer enable timing.
    task automatic t_read_normal();
        int r0;
        r0 = rd_cnt;
        step(1);
        bus_addr = 19'h2_2222; ce_n = 1'b0; oe_n = 1'b0;
        step(1);
        chk(dq_oe == 1'b0, "R2 one edge", int'(dq_oe), 0);
        bus_addr = 19'h3_3333;
        step(1);
        chk(dq_oe == 1'b1, "R2 two edges", int'(dq_oe), 1);
        step(3); oe_n = 1'b1; ce_n = 1'b1; step(5);
        chk(dq_oe == 1'b0, "R2 released", int'(dq_oe), 0);
        chk(rd_cnt == r0 + 1, "R6 one read", rd_cnt - r0, 1);
        chk(last_ra == 19'h2_2222, "R6 start addr", int'(last_ra), 'h22222);
    endtask

    // R7: protection tracking reports the last address at read end.
    task automatic t_read_prot();
        int r0, t_end;
        r0 = rd_cnt;
        prot_track = 1'b1; step(1);
        bus_addr = 19'h4_0000; ce_n = 1'b0; oe_n = 1'b0; step(2);
        bus_addr = 19'h4_ABCD; step(2);
        oe_n = 1'b1; bus_addr = 19'h0; t_end = cyc; step(5);
        chk(rd_cnt == r0 + 1, "R7 one read", rd_cnt - r0, 1);
        chk(last_ra == 19'h4_ABCD, "R7 end addr", int'(last_ra), 'h4ABCD);
        chk(rd_cyc - t_end == 3, "R7 at end", rd_cyc - t_end, 3);
        ce_n = 1'b1; step(3); prot_track = 1'b0; step(2);
    endtask

    // R9: write end and read start on the same sample.
    task automatic t_conflict();
        int w0, r0;
        w0 = wr_cnt; r0 = rd_cnt;
        step(1);
        bus_addr = 19'h6_1111; bus_data = 8'h5A; ce_n = 1'b0; we_n = 1'b0;
        step(3);
        we_n = 1'b1; oe_n = 1'b0; bus_addr = 19'h6_2222; bus_data = 8'h00;
        step(4); ce_n = 1'b1; oe_n = 1'b1; step(5);
        chk(wr_cnt == w0 + 1, "R9 write issued", wr_cnt - w0, 1);
        chk(rd_cnt == r0 + 1, "R9 read issued", rd_cnt - r0, 1);
        chk(last_wa == 19'h6_1111 && last_wd == 8'h5A, "R9 write payload",
            int'(last_wa), 'h61111);
        chk(last_ra == 19'h6_2222, "R9 read addr", int'(last_ra), 'h62222);
        chk(rd_cyc - wr_cyc == 1, "R9 read one clock later", rd_cyc - wr_cyc, 1);
        chk(both_cnt == 0, "R9 never same clock", both_cnt, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        step(3);
        rst_n = 1'b1;
        t_reset();
        t_write_basic();
        t_write_ce_late();
        t_inhibit();
        t_deselect();
        t_read_normal();
        t_read_prot();
        t_conflict();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule